// File: doc/BRIEF.md
# Edge-Triggered Event Interrupt Controller

This block is the interrupt front end of a network-style peripheral. It keeps a 16-bit event status register and a 16-bit interrupt enable mask. Hardware raises events as one-cycle pulses on a bit vector. Software reads both registers through a small register port and acknowledges events by writing ones to the status register.

The block raises a single-cycle message interrupt only when the enabled subset of the status (status AND mask) goes from all-zero to non-zero. While that subset stays non-zero, newly arriving events raise no further interrupt. A driver therefore has to bring the enabled subset back to zero to re-arm the interrupt. It can do this by clearing every pending bit, or by writing the mask to zero and enabling it again later.

The register port carries no back-pressure and accepts one request in every cycle where `reg_valid_i` is high. A read request returns its data, registered, in the next cycle, marked by `reg_rvalid_o`. Writes take effect at the clock edge that samples them.

Top module: `evt_irq_ctrl`

## Requirements
- R1: Reset clears the status and the mask to zero and holds `msi_o` low.
- R2: An event pulse on `evt_i` bit n sets status bit n at the next clock edge, and the bit stays set until software clears it. The event positions are: receive done = bit 0, transmit done = bit 2, link change = bit 5, receive FIFO overflow = bit 6, no transmit descriptor = bit 7, system error = bit 15.
- R3: A write to the status address (0) clears each status bit whose write-data bit is one. Bits written as zero keep their value.
- R4: If an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R5: `msi_o` is high for exactly one clock, starting at the edge where status AND mask changes from zero to non-zero.
- R6: While status AND mask stays non-zero, `msi_o` stays low, even when further enabled events arrive. For example, with status 0x01, events 0x04 and 0x80, then an acknowledge of 0x01, the status becomes 0x84 and no pulse is raised.
- R7: Writing zero to the mask address (1) forces status AND mask to zero without changing the status. A later mask write that enables a bit that is still set produces a fresh pulse.
- R8: Events whose mask bit is zero still set status, but they raise no pulse.
- R9: A read returns the status (address 0), the last written mask (address 1), or zero (any other address) one cycle after the request, with `reg_rvalid_o` high for that cycle. Reading has no side effect.
- R10: Once status AND mask has returned to zero by clearing, the next enabled event raises a new pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 16 | Hardware event pulses, one bit per event |
| reg_valid_i | input | 1 | Register request valid |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 2 | Register address: 0 status, 1 mask |
| reg_wdata_i | input | 16 | Write data (ones to clear for status) |
| reg_rdata_o | output | 16 | Read data, valid with reg_rvalid_o |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after the read request |
| msi_o | output | 1 | One-cycle message interrupt pulse |

## Verification
A hardware event and a software write-one-to-clear can land on the same status register in the same cycle. The bench drives both at once on the same bit and checks that the bit survives. It also drives both at once on different bits, in the acknowledge race where 0x01 is read, events 0x84 arrive, and then 0x01 is written back. It judges that case by reading back 0x84 and by counting no extra interrupt pulse. Mask writes that coincide with set status are likewise checked for a pulse that appears exactly when the enabled subset leaves zero.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK   = 2'd1;

  // event bit positions
  localparam int EVB_RX_DONE   = 0;
  localparam int EVB_TX_DONE   = 2;
  localparam int EVB_LINK      = 5;
  localparam int EVB_RX_OVF    = 6;
  localparam int EVB_TX_NODESC = 7;
  localparam int EVB_SYS_ERR   = 15;
endpackage

// File: rtl/evt_status_reg.sv
module evt_status_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_q,
  output logic [W-1:0] status_nxt
);
  // one slice per bit: a set beats a clear in the same cycle
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign status_nxt[b] = set_i[b] | (status_q[b] & ~clr_i[b]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q[b] <= 1'b0;
      else        status_q[b] <= status_nxt[b];
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] mask_nxt
);
  assign mask_nxt = wr_en_i ? wdata_i : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_nxt;
  end
endmodule

// File: rtl/irq_rise_pulse.sv
module irq_rise_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_nxt_i,
  input  logic pend_cur_i,
  output logic pulse_o
);
  // registered so the pulse lines up with the new register contents
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_o <= 1'b0;
    else        pulse_o <= pend_nxt_i & ~pend_cur_i;
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int REG_W  = evt_irq_pkg::REG_W,
  parameter int ADDR_W = evt_irq_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  evt_i,
  input  logic              reg_valid_i,
  input  logic              reg_write_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              reg_rvalid_o,
  output logic              msi_o
);
  logic [REG_W-1:0] status_q, status_nxt;
  logic [REG_W-1:0] mask_q, mask_nxt;
  logic [REG_W-1:0] clr_vec;
  logic             wr_status, wr_mask, rd_req;
  logic             pend_cur, pend_nxt;
  logic [REG_W-1:0] rdata_mux;

  assign wr_status = reg_valid_i & reg_write_i & (reg_addr_i == ADDR_STATUS[ADDR_W-1:0]);
  assign wr_mask   = reg_valid_i & reg_write_i & (reg_addr_i == ADDR_MASK[ADDR_W-1:0]);
  assign rd_req    = reg_valid_i & ~reg_write_i;
  assign clr_vec   = wr_status ? reg_wdata_i : '0;

  evt_status_reg #(.W(REG_W)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (evt_i),
    .clr_i      (clr_vec),
    .status_q   (status_q),
    .status_nxt (status_nxt)
  );

  irq_mask_reg #(.W(REG_W)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_mask),
    .wdata_i  (reg_wdata_i),
    .mask_q   (mask_q),
    .mask_nxt (mask_nxt)
  );

  assign pend_cur = |(status_q & mask_q);
  assign pend_nxt = |(status_nxt & mask_nxt);

  irq_rise_pulse u_pulse (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_nxt_i (pend_nxt),
    .pend_cur_i (pend_cur),
    .pulse_o    (msi_o)
  );

  always_comb begin
    if (reg_addr_i == ADDR_STATUS[ADDR_W-1:0])    rdata_mux = status_q;
    else if (reg_addr_i == ADDR_MASK[ADDR_W-1:0]) rdata_mux = mask_q;
    else                                          rdata_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata_o  <= '0;
      reg_rvalid_o <= 1'b0;
    end else begin
      reg_rvalid_o <= rd_req;
      if (rd_req) reg_rdata_o <= rdata_mux;
    end
  end
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
  parameter int W  = 16,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  evt_i,
  input logic          reg_valid_i,
  input logic          reg_write_i,
  input logic [AW-1:0] reg_addr_i,
  input logic [W-1:0]  reg_wdata_i,
  input logic          reg_rvalid_o,
  input logic          msi_o,
  input logic [W-1:0]  status_q,
  input logic [W-1:0]  mask_q
);
  logic pend;
  logic wr_st, wr_mk;
  assign pend  = |(status_q & mask_q);
  assign wr_st = reg_valid_i & reg_write_i & (reg_addr_i == '0);
  assign wr_mk = reg_valid_i & reg_write_i & (reg_addr_i == AW'(1));

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i))); // R4

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_st |=> ((status_q & $past(reg_wdata_i) & ~$past(evt_i)) == '0)); // R3

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    msi_o |=> !msi_o); // R5

  AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    msi_o |-> (pend && !$past(pend))); // R5

  AST_NO_PULSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && $past(pend)) |-> !msi_o); // R6

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mk |=> $stable(mask_q)); // R9

  AST_READ_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid_i && !reg_write_i) |=> reg_rvalid_o); // R9
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.W(REG_W), .AW(ADDR_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .evt_i        (evt_i),
  .reg_valid_i  (reg_valid_i),
  .reg_write_i  (reg_write_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .reg_rvalid_o (reg_rvalid_o),
  .msi_o        (msi_o),
  .status_q     (status_q),
  .mask_q       (mask_q)
);

// File: tb/evt_irq_ctrl_tb.sv
`timescale 1ns/100ps
module evt_irq_ctrl_tb_top;
  localparam real CLK_HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt_i = '0;
  logic        reg_valid_i = 1'b0;
  logic        reg_write_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        reg_rvalid_o;
  logic        msi_o;

  int n_chk = 0;
  int n_fail = 0;
  int irq_cnt = 0;
  int run_len = 0;
  int max_run = 0;

  evt_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .reg_valid_i(reg_valid_i), .reg_write_i(reg_write_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .reg_rvalid_o(reg_rvalid_o), .msi_o(msi_o)
  );

  always #(CLK_HALF) clk = ~clk;

  // pulse monitor, samples 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (msi_o) begin
      irq_cnt++;
      run_len++;
      if (run_len > max_run) max_run = run_len;
    end else begin
      run_len = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one clock of stimulus; returns 3 ns after the edge, past the monitor
  task automatic cycle(input logic [15:0] ev, input bit vld, input bit wr,
                       input logic [1:0] addr, input logic [15:0] wd);
    evt_i = ev; reg_valid_i = vld; reg_write_i = wr;
    reg_addr_i = addr; reg_wdata_i = wd;
    @(posedge clk); #1;
    evt_i = '0; reg_valid_i = 1'b0; reg_write_i = 1'b0;
    reg_addr_i = '0; reg_wdata_i = '0;
    #2;
  endtask

  task automatic wr_reg(input logic [1:0] addr, input logic [15:0] wd);
    cycle('0, 1'b1, 1'b1, addr, wd);
  endtask

  task automatic rd_reg(input logic [1:0] addr, output logic [15:0] val, output bit vld);
    cycle('0, 1'b1, 1'b0, addr, '0);
    val = reg_rdata_o;
    vld = reg_rvalid_o;
  endtask

  task automatic idle();
    cycle('0, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic t_reset();
    logic [15:0] v; bit vl;
    check(msi_o == 1'b0, "R1 irq low", msi_o, 0);
    rd_reg(2'd0, v, vl);
    check(v == 16'h0, "R1 status", v, 0);
    rd_reg(2'd1, v, vl);
    check(v == 16'h0, "R1 mask", v, 0);
  endtask

  task automatic t_set_and_read();
    logic [15:0] v; bit vl;
    int c0 = irq_cnt;
    cycle(16'h8000, 1'b0, 1'b0, '0, '0);   // system error, masked off
    cycle(16'h0060, 1'b0, 1'b0, '0, '0);   // link change + rx overflow
    idle();
    rd_reg(2'd0, v, vl);
    check(vl == 1'b1, "R9 rvalid", vl, 1);
    check(v == 16'h8060, "R2 status bits held", v, 16'h8060);
    rd_reg(2'd0, v, vl);
    check(v == 16'h8060, "R9 read no side effect", v, 16'h8060);
    check(irq_cnt == c0, "R8 masked events no pulse", irq_cnt - c0, 0);
    rd_reg(2'd2, v, vl);
    check(v == 16'h0, "R9 unmapped reads zero", v, 0);
    wr_reg(2'd0, 16'h0040);
    rd_reg(2'd0, v, vl);
    check(v == 16'h8020, "R3 partial w1c", v, 16'h8020);
  endtask

  task automatic t_set_wins();
    logic [15:0] v; bit vl;
    cycle(16'h0020, 1'b1, 1'b1, 2'd0, 16'h0020);   // set and clear same bit
    rd_reg(2'd0, v, vl);
    check(v == 16'h8020, "R4 set wins", v, 16'h8020);
    wr_reg(2'd0, 16'hFFFF);
    rd_reg(2'd0, v, vl);
    check(v == 16'h0, "R3 clear all", v, 0);
  endtask

  task automatic t_ack_race();
    logic [15:0] v; bit vl;
    int c0;
    wr_reg(2'd1, 16'h80E5);
    rd_reg(2'd1, v, vl);
    check(v == 16'h80E5, "R9 mask readback", v, 16'h80E5);
    c0 = irq_cnt;
    cycle(16'h0001, 1'b0, 1'b0, '0, '0);   // rx done
    check(irq_cnt == c0 + 1, "R5 first pulse", irq_cnt - c0, 1);
    rd_reg(2'd0, v, vl);
    check(v == 16'h0001, "R2 rx done bit0", v, 1);
    cycle(16'h0084, 1'b0, 1'b0, '0, '0);   // tx done + no descriptor
    wr_reg(2'd0, 16'h0001);                // ack stale snapshot
    rd_reg(2'd0, v, vl);
    check(v == 16'h0084, "R6 residue after ack", v, 16'h84);
    check(irq_cnt == c0 + 1, "R6 no new pulse", irq_cnt - c0, 1);
    // R7: mask to zero then re-enable
    wr_reg(2'd1, 16'h0000);
    rd_reg(2'd0, v, vl);
    check(v == 16'h0084, "R7 mask write keeps status", v, 16'h84);
    check(irq_cnt == c0 + 1, "R7 no pulse on disable", irq_cnt - c0, 1);
    wr_reg(2'd1, 16'h0004);
    check(irq_cnt == c0 + 2, "R7 fresh pulse on enable", irq_cnt - c0, 2);
    wr_reg(2'd0, 16'hFFFF);
  endtask

  task automatic t_rearm();
    int c0;
    wr_reg(2'd1, 16'h0001);
    c0 = irq_cnt;
    cycle(16'h0001, 1'b0, 1'b0, '0, '0);
    cycle(16'h0001, 1'b0, 1'b0, '0, '0);   // repeated event while pending
    idle();
    check(irq_cnt == c0 + 1, "R6 single pulse while pending", irq_cnt - c0, 1);
    wr_reg(2'd0, 16'h0001);
    idle();
    cycle(16'h0001, 1'b0, 1'b0, '0, '0);
    idle();
    check(irq_cnt == c0 + 2, "R10 rearm after clear", irq_cnt - c0, 2);
    wr_reg(2'd1, 16'h0000);
    wr_reg(2'd0, 16'hFFFF);
    check(max_run == 1, "R5 pulse width", max_run, 1);
  endtask

  bit done = 0;

  initial begin
    #(CLK_HALF * 2 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    t_reset();
    t_set_and_read();
    t_set_wins();
    t_ack_race();
    t_rearm();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule